// File: doc/BRIEF.md
# Phase-Interpolator Clock and Data Recovery Loop Controller

This block is the digital steering loop of a receiver that recovers a clock by rotating phase interpolators. Two samplers watch the incoming serial line. One is aimed at the points where bits change, called the edge sampler. The other is aimed at the middle of each bit, called the data sampler. Once per qualified cycle the block receives one data decision and the edge decision taken between that bit and the previous one. Each time the data changes, the block judges whether the edge sampler fired before or after the true crossing. It then steers a shared phase so that the edge sampler settles on the crossings.

Two interpolator codes leave the block. Both move together, and the data code always sits a quarter of the code range (90 degrees) after the edge code. This places the data decision halfway between crossings. Single votes are filtered through a bounded accumulator before the phase moves. A slow frequency integrator adds a second-order term, so a steady rate offset between the line and the local reference is tracked without a standing phase error. Each data decision is also passed out as a recovered bit with a valid flag.

Top module: `cdr_pi_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge `edge_code` becomes 0, `data_code` becomes 16, `rx_valid` becomes 0, and the vote accumulator, frequency register and fractional register all clear.
- R2: At every cycle `data_code` equals `edge_code + 16` modulo 64.
- R3: A vote is cast only on a cycle with `smp_valid` high, and only when this cycle's `dat_smp` differs from the `dat_smp` of the most recent earlier valid cycle since reset. The first valid sample after reset casts no vote, and equal consecutive samples cast none.
- R4: On a vote, `edg_smp` equal to the current `dat_smp` means the edge sampler is late, giving a vote of -1. `edg_smp` equal to the previous data bit means it is early, giving a vote of +1.
- R5: Votes add into a signed accumulator. When the sum reaches +8 or -8, a proportional step of +1 or -1 is issued and the accumulator returns to 0. Otherwise it keeps the sum.
- R6: On every valid cycle, the frequency register (before its update) is added into a fractional register. A sum of +256 or more issues a +1 frequency step and subtracts 256. A sum of -256 or less issues a -1 step and adds 256. After that, the frequency register adds the proportional step and saturates at ±31.
- R7: On the edge after a valid sample, `edge_code` becomes its old value plus the proportional step plus the frequency step, modulo 64. With no step it holds.
- R8: One cycle after a valid sample, `rx_valid` is 1 and `rx_data` equals that sample. After a cycle without a valid sample, `rx_valid` is 0.
- R9: While `smp_valid` is low, `dat_smp` and `edg_smp` have no effect: the codes, the loop state and the previous-bit memory stay unchanged.
- R10: When the line crossing phase drifts steadily by one code step every 100 valid cycles, and the edge sampler reports early or late according to the sign of the phase error, the loop holds `edge_code` within ±8 steps of the crossing phase once it has settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Active-high synchronous reset |
| smp_valid | input | 1 | Qualifies `dat_smp` and `edg_smp` this cycle |
| dat_smp | input | 1 | Decision of the mid-bit sampler |
| edg_smp | input | 1 | Decision of the crossing sampler, taken between the previous and current data bits |
| edge_code | output | 6 | Phase code for the crossing-sampler interpolator |
| data_code | output | 6 | Phase code for the mid-bit interpolator |
| rx_data | output | 1 | Recovered data bit |
| rx_valid | output | 1 | Marks `rx_data` as holding a new bit |

## Verification
Every result of a valid sample is due exactly one clock edge later: the vote, the accumulator, the fractional register and both codes are all updated at that edge. The recovered bit and its flag also appear one edge after the sample. The bench therefore drives inputs just after a falling edge and advances its behavioural model by one step per driven cycle. It compares all four outputs at the next falling edge, so each compare lands between the register update and the next drive. For the tracking requirement, the crossing sampler is modelled from the model's own code, and the phase error is measured over the final 2000 cycles of a long run.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  // signed step or vote in {-1, 0, +1}
  typedef logic signed [1:0] step_t;

  // early/late decision from two data bits and the crossing sample between them
  function automatic step_t el_vote(input logic prev_d, input logic cur_d, input logic edg);
    if (prev_d == cur_d) return 2'sd0;
    if (edg == cur_d)    return -2'sd1;  // crossing already passed: late
    return 2'sd1;                        // crossing not yet reached: early
  endfunction

endpackage

// File: rtl/cdr_edge_vote.sv
module cdr_edge_vote
  import cdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  smp_valid,
  input  logic  dat_smp,
  input  logic  edg_smp,
  output step_t vote,
  output logic  rx_data,
  output logic  rx_valid
);

  logic has_prev;
  logic prev_bit;
  logic trans;

  assign trans = smp_valid && has_prev && (prev_bit != dat_smp);
  assign vote  = trans ? el_vote(prev_bit, dat_smp, edg_smp) : 2'sd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      has_prev <= 1'b0;
      prev_bit <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= 1'b0;
    end else begin
      rx_valid <= smp_valid;
      if (smp_valid) begin
        has_prev <= 1'b1;
        prev_bit <= dat_smp;
        rx_data  <= dat_smp;
      end
    end
  end

  assert_vote_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (vote != 2'sd0) |-> (smp_valid && has_prev));

  assert_rx_follow_R8: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (rx_valid && rx_data == $past(dat_smp)));

  assert_rx_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !rx_valid);

  assert_prev_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(prev_bit) && $stable(has_prev)));

endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter
  import cdr_pkg::*;
#(
  parameter int ACC_LIM  = 8,
  parameter int FREQ_MAX = 31,
  parameter int FRAC_LIM = 256
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  smp_valid,
  input  step_t vote,
  output step_t pstep,
  output step_t fstep
);

  localparam int ACC_W = $clog2(ACC_LIM) + 2;
  localparam int FRQ_W = $clog2(FREQ_MAX + 1) + 2;
  localparam int FRC_W = $clog2(FRAC_LIM) + 2;

  localparam logic signed [ACC_W-1:0] ACC_HI = ACC_W'(ACC_LIM);
  localparam logic signed [ACC_W-1:0] ACC_LO = -ACC_W'(ACC_LIM);
  localparam logic signed [FRQ_W-1:0] FRQ_HI = FRQ_W'(FREQ_MAX);
  localparam logic signed [FRQ_W-1:0] FRQ_LO = -FRQ_W'(FREQ_MAX);
  localparam logic signed [FRC_W-1:0] FRC_HI = FRC_W'(FRAC_LIM);
  localparam logic signed [FRC_W-1:0] FRC_LO = -FRC_W'(FRAC_LIM);

  logic signed [ACC_W-1:0] acc, acc_sum, acc_n;
  logic signed [FRQ_W-1:0] freq, freq_n;
  logic signed [FRC_W-1:0] frac, frac_sum, frac_n;

  function automatic logic signed [FRQ_W-1:0] clamp_freq(input logic signed [FRQ_W-1:0] v);
    if (v > FRQ_HI) return FRQ_HI;
    if (v < FRQ_LO) return FRQ_LO;
    return v;
  endfunction

  assign acc_sum  = acc + ACC_W'(vote);
  assign frac_sum = frac + FRC_W'(freq);

  always_comb begin
    pstep  = 2'sd0;
    fstep  = 2'sd0;
    acc_n  = acc;
    frac_n = frac;
    freq_n = freq;
    if (smp_valid) begin
      acc_n = acc_sum;
      if (acc_sum >= ACC_HI) begin
        pstep = 2'sd1;
        acc_n = '0;
      end else if (acc_sum <= ACC_LO) begin
        pstep = -2'sd1;
        acc_n = '0;
      end
      frac_n = frac_sum;
      if (frac_sum >= FRC_HI) begin
        fstep  = 2'sd1;
        frac_n = frac_sum - FRC_HI;
      end else if (frac_sum <= FRC_LO) begin
        fstep  = -2'sd1;
        frac_n = frac_sum - FRC_LO;
      end
      freq_n = clamp_freq(freq + FRQ_W'(pstep));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      freq <= '0;
      frac <= '0;
    end else begin
      acc  <= acc_n;
      freq <= freq_n;
      frac <= frac_n;
    end
  end

  assert_acc_inside_R5: assert property (@(posedge clk) disable iff (rst)
    (acc > ACC_LO) && (acc < ACC_HI));

  assert_acc_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (pstep != 2'sd0) |=> (acc == '0));

  assert_freq_clamp_R6: assert property (@(posedge clk) disable iff (rst)
    (freq <= FRQ_HI) && (freq >= FRQ_LO));

  assert_frac_inside_R6: assert property (@(posedge clk) disable iff (rst)
    (frac > FRC_LO) && (frac < FRC_HI));

  assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(acc) && $stable(freq) && $stable(frac)));

endmodule

// File: rtl/cdr_phase_reg.sv
module cdr_phase_reg
  import cdr_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  step_t             pstep,
  input  step_t             fstep,
  output logic [CODE_W-1:0] edge_code,
  output logic [CODE_W-1:0] data_code
);

  localparam logic [CODE_W-1:0] QTR = CODE_W'(1 << (CODE_W - 2));

  logic signed [2:0]  delta;
  logic [CODE_W-1:0]  move;
  logic [CODE_W-1:0]  edge_plus_qtr;

  assign delta         = 3'(pstep) + 3'(fstep);
  assign move          = CODE_W'(delta);
  assign edge_plus_qtr = edge_code + QTR;

  // the two codes are kept in separate registers stepped by the same move
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_code <= '0;
      data_code <= QTR;
    end else begin
      edge_code <= edge_code + move;
      data_code <= data_code + move;
    end
  end

  assert_quarter_R2: assert property (@(posedge clk) disable iff (rst)
    data_code == edge_plus_qtr);

  assert_still_R7: assert property (@(posedge clk) disable iff (rst)
    (pstep == 2'sd0 && fstep == 2'sd0) |=> $stable(edge_code));

endmodule

// File: rtl/cdr_pi_ctrl.sv
module cdr_pi_ctrl
  import cdr_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int ACC_LIM  = 8,
  parameter int FREQ_MAX = 31,
  parameter int FRAC_LIM = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic              dat_smp,
  input  logic              edg_smp,
  output logic [CODE_W-1:0] edge_code,
  output logic [CODE_W-1:0] data_code,
  output logic              rx_data,
  output logic              rx_valid
);

  step_t vote;
  step_t pstep;
  step_t fstep;

  cdr_edge_vote u_vote (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .dat_smp   (dat_smp),
    .edg_smp   (edg_smp),
    .vote      (vote),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );

  cdr_loop_filter #(
    .ACC_LIM  (ACC_LIM),
    .FREQ_MAX (FREQ_MAX),
    .FRAC_LIM (FRAC_LIM)
  ) u_filt (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .vote      (vote),
    .pstep     (pstep),
    .fstep     (fstep)
  );

  cdr_phase_reg #(
    .CODE_W (CODE_W)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .pstep     (pstep),
    .fstep     (fstep),
    .edge_code (edge_code),
    .data_code (data_code)
  );

  assert_idle_codes_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(edge_code) && $stable(data_code)));

endmodule

// File: tb/tb_cdr_pi_ctrl.sv
module tb_cdr_pi_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic       dat_smp = 1'b0;
  logic       edg_smp = 1'b0;
  logic [5:0] edge_code;
  logic [5:0] data_code;
  logic       rx_data;
  logic       rx_valid;

  always #4 clk = ~clk;  // 125 MHz

  cdr_pi_ctrl dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .dat_smp(dat_smp), .edg_smp(edg_smp),
    .edge_code(edge_code), .data_code(data_code), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  int checks = 0;
  int fails  = 0;
  string phase_req = "R1";

  // behavioural reference state
  int m_edge, m_acc, m_f, m_frac, m_prev;
  bit m_has, m_rxv, m_rxd;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s/%s %s actual=%0d expected=%0d", phase_req, req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_edge = 0; m_acc = 0; m_f = 0; m_frac = 0; m_prev = 0;
    m_has = 0; m_rxv = 0; m_rxd = 0;
  endtask

  task automatic model_step(input bit v, input bit d, input bit e);
    int vote, p, fs, a, r;
    m_rxv = v;
    if (!v) return;
    m_rxd = d;
    vote = 0;
    if (m_has && m_prev != d) vote = (e == d) ? -1 : 1;
    m_has = 1; m_prev = d;
    a = m_acc + vote; p = 0;
    if (a >= 8) begin p = 1; a = 0; end
    else if (a <= -8) begin p = -1; a = 0; end
    m_acc = a;
    r = m_frac + m_f; fs = 0;
    if (r >= 256) begin fs = 1; r -= 256; end
    else if (r <= -256) begin fs = -1; r += 256; end
    m_frac = r;
    m_f = m_f + p;
    if (m_f > 31) m_f = 31;
    if (m_f < -31) m_f = -31;
    m_edge = (m_edge + p + fs + 64) % 64;
  endtask

  task automatic compare_all();
    check("R7", "edge_code", int'(edge_code), m_edge);
    check("R2", "data_code", int'(data_code), (m_edge + 16) % 64);
    check("R8", "rx_valid", int'(rx_valid), int'(m_rxv));
    if (m_rxv) check("R8", "rx_data", int'(rx_data), int'(m_rxd));
  endtask

  // one cycle: compare previous result, then drive and advance the model
  task automatic cyc(input bit v, input bit d, input bit e);
    @(negedge clk);
    compare_all();
    smp_valid = v; dat_smp = d; edg_smp = e;
    model_step(v, d, e);
  endtask

  task automatic do_reset();
    smp_valid = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk);
    check("R1", "edge_code after reset", int'(edge_code), 0);
    check("R1", "data_code after reset", int'(data_code), 16);
    check("R1", "rx_valid after reset", int'(rx_valid), 0);
    rst = 0;
  endtask

  function automatic int wrap_err(input int code, input int line);
    int d;
    d = (code - line + 64 + 32) % 64;
    return d - 32;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int line, maxerr, err;
    bit d, e;
    phase_req = "R1";
    do_reset();

    // R3: constant data, no transitions, codes must hold
    phase_req = "R3";
    for (int i = 0; i < 40; i++) cyc(1, 1, i[0]);
    check("R3", "edge_code unchanged without transitions", int'(edge_code), 0);

    // R4/R5: late pattern, alternating data with edge equal to current bit
    phase_req = "R4";
    for (int i = 0; i < 60; i++) cyc(1, i[0], i[0]);
    // R4/R5: early pattern, edge equal to previous bit
    phase_req = "R5";
    for (int i = 0; i < 60; i++) cyc(1, i[0], ~i[0]);

    // R9: inputs toggle with valid low, nothing may move
    phase_req = "R9";
    for (int i = 0; i < 25; i++) cyc(0, i[0], i[1]);
    // R9: next valid sample pairs with the last valid one; mix gaps and samples
    for (int i = 0; i < 80; i++) cyc(i % 3 != 0, i[1], i[0]);

    // R6: sustained early votes drive the frequency register into saturation
    phase_req = "R6";
    for (int i = 0; i < 1500; i++) cyc(1, i[0], ~i[0]);
    for (int i = 0; i < 1500; i++) cyc(1, i[0], i[0]);

    // R10: closed loop against a drifting crossing phase
    phase_req = "R10";
    do_reset();
    line = 10;
    maxerr = 0;
    for (int i = 0; i < 14000; i++) begin
      d = 1'($urandom_range(0, 1));
      err = wrap_err(m_edge, line);
      if (m_has && m_prev != int'(d)) e = (err < 0) ? m_prev[0] : d;
      else e = 1'($urandom_range(0, 1));
      if (i >= 12000) begin
        if (err < 0) err = -err;
        if (err > maxerr) maxerr = err;
      end
      cyc(1, d, e);
      if (i % 100 == 99) line = (line + 1) % 64;
    end
    check("R10", "max phase error after settling within 8", (maxerr <= 8) ? 1 : 0, 1);

    @(negedge clk);
    compare_all();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule